// File: doc/BRIEF.md
# Calendar Alarm Interrupt Unit

This block watches a running calendar and raises an interrupt when the time reaches a programmed alarm. Seven time fields come in from an external calendar counter: second, minute, hour, day of month, day of week, month and year. A one-cycle strobe marks each seconds update. On every such strobe the unit compares the incoming time with seven stored alarm fields. Any field can be left out of the comparison through a mask register. The unit also records a per-second tick event.

Both events land in a status register, and reading that register clears it. An enable register decides which pending events pull the active-low, level-sensitive interrupt line. The line stays low until software reads the status register. A one-shot mode makes the alarm disarm itself when it fires. Software loads the alarm fields, the mask and the enables through committed register writes.

The fields are raw counter values. The year is a 7-bit offset from 2000 and the month counts from 1. The unit does not interpret either; it only compares them.

Top module: `cal_alarm_irq`

## Requirements
- R1: After reset `irqN` is 1, and the status (0x04), enable (0x08), mask (0x10) and alarm field registers all read 0.
- R2: Alarm fields sit at 0x30 (second), 0x34 (minute), 0x38 (hour), 0x3C (day of month), 0x40 (day of week), 0x44 (month) and 0x48 (year). Their widths are 6, 6, 5, 5, 3, 4 and 7 bits. A write keeps only the low field-width bits, and a read returns them zero-extended. The mask register keeps bits 6:0 and the enable register keeps bits 2:0.
- R3: A cycle with `tickIn` high sets status bit 1 (tick), whatever the enable register holds.
- R4: Status bit 0 (alarm) sets only in a cycle where `tickIn` is high and every unmasked alarm field equals the current time field. Matching time without a tick sets nothing.
- R5: Mask bit i, when 1, removes field i from the comparison. Bits 0 to 6 stand for second, minute, hour, day of month, day of week, month and year, so bit 4 ignores the day of week.
- R6: A read of address 0x04 returns the status as it stood before the read and clears it at that clock edge. An event in the same cycle as the read stays set afterwards.
- R7: `irqN` is 0 exactly when a status bit is pending whose enable was 1 at the moment it was set. Enable bit 0 covers the alarm and bit 1 covers the tick. The line stays 0 until a status read.
- R8: When enable bits 2 (one-shot) and 0 are both 1, an alarm event clears enable bit 0 at the same edge, and that event still drives `irqN` low. Without one-shot, enable bit 0 stays set across alarm events.
- R9: A write to the enable register in the same cycle as a one-shot alarm event takes priority over the self-clear.
- R10: A status bit set while its enable was 0 does not drive `irqN` low, even if the enable is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | One-cycle strobe that marks a seconds update of the time fields |
| curSec | input | 6 | Current second |
| curMin | input | 6 | Current minute |
| curHour | input | 5 | Current hour |
| curDom | input | 5 | Current day of month |
| curDow | input | 3 | Current day of week |
| curMonth | input | 4 | Current month, counting from 1 |
| curYear | input | 7 | Current year as an offset from 2000 |
| regWrEn | input | 1 | Committed register write strobe |
| regRdEn | input | 1 | Register read strobe; a read of 0x04 clears status |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, valid in the same cycle as the address |
| irqN | output | 1 | Active-low level interrupt |

## Verification
Read data comes from a combinational mux, so the bench samples it 1 ns after driving the address, inside the read cycle and before the edge. Status, enable, mask and `irqN` change at the first rising edge after the stimulus cycle, so the bench samples them at the next falling edge. A status read made in the cycle after an event therefore already sees that event. Every call of the cycle task checks `irqN` against a bench model, and the directed cases read the registers back against hand-computed values at those points.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

  localparam int NUM_FIELDS  = 7;
  localparam int FIELD_MAX_W = 7;

  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HOUR_W  = 5;
  localparam int DOM_W   = 5;
  localparam int DOW_W   = 3;
  localparam int MONTH_W = 4;
  localparam int YEAR_W  = 7;

  // status bit positions
  localparam int STA_W     = 2;
  localparam int STA_ALARM = 0;
  localparam int STA_TICK  = 1;

  // enable bit positions
  localparam int EN_W       = 3;
  localparam int EN_ALARM   = 0;
  localparam int EN_TICK    = 1;
  localparam int EN_ONESHOT = 2;

  // register byte offsets
  localparam int ADDR_STATUS  = 'h04;
  localparam int ADDR_ENABLE  = 'h08;
  localparam int ADDR_MASK    = 'h10;
  localparam int ALARM_BASE   = 'h30;
  localparam int FIELD_STRIDE = 4;

  function automatic int fieldWidth(input int idx);
    case (idx)
      0:       return SEC_W;
      1:       return MIN_W;
      2:       return HOUR_W;
      3:       return DOM_W;
      4:       return DOW_W;
      5:       return MONTH_W;
      default: return YEAR_W;
    endcase
  endfunction

  typedef struct packed {
    logic                  wrEnable;
    logic                  wrMask;
    logic [NUM_FIELDS-1:0] wrField;
    logic                  rdStatus;
    logic                  tickEvt;
    logic                  alarmEvt;
    logic                  selfDisable;
  } ctrlStrobes_t;

endpackage

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              tickIn,
  input  logic              matchAll,
  input  logic              alarmEnable,
  input  logic              oneShot,
  output ctrlStrobes_t      strobes
);

  logic [NUM_FIELDS-1:0] fieldSel;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gDecode
    localparam int FIELD_ADDR = ALARM_BASE + g * FIELD_STRIDE;
    assign fieldSel[g] = (regAddr == ADDR_W'(FIELD_ADDR));
  end

  always_comb begin
    strobes.wrEnable    = regWrEn && (regAddr == ADDR_W'(ADDR_ENABLE));
    strobes.wrMask      = regWrEn && (regAddr == ADDR_W'(ADDR_MASK));
    strobes.wrField     = regWrEn ? fieldSel : '0;
    strobes.rdStatus    = regRdEn && (regAddr == ADDR_W'(ADDR_STATUS));
    strobes.tickEvt     = tickIn;
    strobes.alarmEvt    = tickIn && matchAll;
    // software write to the enable register outranks the one-shot disarm
    strobes.selfDisable = tickIn && matchAll && alarmEnable && oneShot
                          && !strobes.wrEnable;
  end

endmodule

// File: rtl/cal_alarm_dp.sv
module cal_alarm_dp
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobes_t                    strobes,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [DATA_W-1:0]               regWrData,
  input  logic [NUM_FIELDS*FIELD_MAX_W-1:0] curFlat,
  output logic                            matchAll,
  output logic [EN_W-1:0]                 enBits,
  output logic [STA_W-1:0]                staBits,
  output logic [STA_W-1:0]                armBits,
  output logic [DATA_W-1:0]               regRdData,
  output logic                            irqN
);

  logic [NUM_FIELDS-1:0]  maskReg;
  logic [NUM_FIELDS-1:0]  fieldHit;
  logic [FIELD_MAX_W-1:0] fieldVal [NUM_FIELDS];
  logic [STA_W-1:0]       evtVec;
  logic [STA_W-1:0]       evtEnabled;

  // alarm field storage and per-field comparators
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    localparam int W = fieldWidth(g);
    logic [W-1:0] value;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        value <= '0;
      end else if (strobes.wrField[g]) begin
        value <= regWrData[W-1:0];
      end
    end

    assign fieldVal[g] = FIELD_MAX_W'(value);
    assign fieldHit[g] = maskReg[g] | (value == curFlat[g*FIELD_MAX_W +: W]);
  end

  assign matchAll = &fieldHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
    end else if (strobes.wrMask) begin
      maskReg <= regWrData[NUM_FIELDS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBits <= '0;
    end else if (strobes.wrEnable) begin
      enBits <= regWrData[EN_W-1:0];
    end else if (strobes.selfDisable) begin
      enBits[EN_ALARM] <= 1'b0;
    end
  end

  always_comb begin
    evtVec               = '0;
    evtVec[STA_ALARM]    = strobes.alarmEvt;
    evtVec[STA_TICK]     = strobes.tickEvt;
    evtEnabled           = '0;
    evtEnabled[STA_ALARM] = strobes.alarmEvt && enBits[EN_ALARM];
    evtEnabled[STA_TICK]  = strobes.tickEvt && enBits[EN_TICK];
  end

  // status: clear-on-read, a same-cycle event survives the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      staBits <= '0;
      armBits <= '0;
    end else begin
      staBits <= (strobes.rdStatus ? '0 : staBits) | evtVec;
      armBits <= (strobes.rdStatus ? '0 : armBits) | evtEnabled;
    end
  end

  assign irqN = ~|armBits;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_STATUS)) begin
      regRdData[STA_W-1:0] = staBits;
    end else if (regAddr == ADDR_W'(ADDR_ENABLE)) begin
      regRdData[EN_W-1:0] = enBits;
    end else if (regAddr == ADDR_W'(ADDR_MASK)) begin
      regRdData[NUM_FIELDS-1:0] = maskReg;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (regAddr == ADDR_W'(ALARM_BASE + i * FIELD_STRIDE)) begin
          regRdData[FIELD_MAX_W-1:0] = fieldVal[i];
        end
      end
    end
  end

endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic [SEC_W-1:0]  curSec,
  input  logic [MIN_W-1:0]  curMin,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [DOM_W-1:0]  curDom,
  input  logic [DOW_W-1:0]  curDow,
  input  logic [MONTH_W-1:0] curMonth,
  input  logic [YEAR_W-1:0] curYear,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqN
);

  logic [NUM_FIELDS*FIELD_MAX_W-1:0] curFlat;
  ctrlStrobes_t     strobes;
  logic             matchAll;
  logic [EN_W-1:0]  enBits;
  logic [STA_W-1:0] staBits;
  logic [STA_W-1:0] armBits;

  assign curFlat = {
    FIELD_MAX_W'(curYear), FIELD_MAX_W'(curMonth), FIELD_MAX_W'(curDow),
    FIELD_MAX_W'(curDom),  FIELD_MAX_W'(curHour),  FIELD_MAX_W'(curMin),
    FIELD_MAX_W'(curSec)
  };

  cal_alarm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .tickIn     (tickIn),
    .matchAll   (matchAll),
    .alarmEnable(enBits[EN_ALARM]),
    .oneShot    (enBits[EN_ONESHOT]),
    .strobes    (strobes)
  );

  cal_alarm_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .curFlat  (curFlat),
    .matchAll (matchAll),
    .enBits   (enBits),
    .staBits  (staBits),
    .armBits  (armBits),
    .regRdData(regRdData),
    .irqN     (irqN)
  );

endmodule

// File: rtl/cal_alarm_checker.sv
module cal_alarm_checker
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickIn,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              irqN,
  input logic              matchAll,
  input logic [EN_W-1:0]   enBits,
  input logic [STA_W-1:0]  staBits
);

  logic rdSta;
  logic wrEn;
  assign rdSta = regRdEn && (regAddr == ADDR_W'(ADDR_STATUS));
  assign wrEn  = regWrEn && (regAddr == ADDR_W'(ADDR_ENABLE));

  assert_tick_sets_status_R3: assert property (@(posedge clk) disable iff (!rstN)
    tickIn |=> staBits[STA_TICK]);

  assert_match_sets_alarm_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && matchAll) |=> staBits[STA_ALARM]);

  assert_no_event_without_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    !tickIn |=> ((staBits & ~$past(staBits)) == '0));

  assert_read_clears_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdSta && !tickIn) |=> (staBits == '0));

  assert_irq_needs_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (staBits != '0));

  assert_oneshot_disarms_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && matchAll && enBits[EN_ALARM] && enBits[EN_ONESHOT] && !wrEn)
    |=> !enBits[EN_ALARM]);

endmodule

bind cal_alarm_irq cal_alarm_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .tickIn  (tickIn),
  .regWrEn (regWrEn),
  .regRdEn (regRdEn),
  .regAddr (regAddr),
  .irqN    (irqN),
  .matchAll(matchAll),
  .enBits  (enBits),
  .staBits (staBits)
);

// File: tb/cal_alarm_irq_bench.sv
`timescale 1ns/1ps
module cal_alarm_irq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic [5:0]  curSec = '0;
  logic [5:0]  curMin = '0;
  logic [4:0]  curHour = '0;
  logic [4:0]  curDom = '0;
  logic [2:0]  curDow = '0;
  logic [3:0]  curMonth = '0;
  logic [6:0]  curYear = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model
  int mAlarm [7];
  int mCur [7];
  int mMask = 0;
  int mEn = 0;
  int mSta = 0;
  int mArm = 0;

  always #10 clk = ~clk;

  cal_alarm_irq u_cal_alarm_irq (
    .clk(clk), .rstN(rstN), .tickIn(tickIn),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDom(curDom),
    .curDow(curDow), .curMonth(curMonth), .curYear(curYear),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqN(irqN)
  );

  function automatic int fw(input int i);
    case (i)
      0: return 6; 1: return 6; 2: return 5; 3: return 5;
      4: return 3; 5: return 4; default: return 7;
    endcase
  endfunction

  function automatic bit modelMatch();
    for (int i = 0; i < 7; i++) begin
      if (!mMask[i] && (mCur[i] != mAlarm[i])) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic int modelRead(input int addr);
    if (addr == 'h04) return mSta;
    if (addr == 'h08) return mEn;
    if (addr == 'h10) return mMask;
    for (int i = 0; i < 7; i++) begin
      if (addr == 'h30 + 4 * i) return mAlarm[i];
    end
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one clock cycle; called at a falling edge, returns at the next one
  task automatic cycle(input bit tick, input bit wr, input bit rd,
                       input int addr, input int data, output int rdVal);
    bit aEvt;
    bit rdS;
    int nSta;
    int nArm;
    tickIn = tick; regWrEn = wr; regRdEn = rd;
    regAddr = 8'(addr); regWrData = 16'(data);
    curSec = 6'(mCur[0]); curMin = 6'(mCur[1]); curHour = 5'(mCur[2]);
    curDom = 5'(mCur[3]); curDow = 3'(mCur[4]); curMonth = 4'(mCur[5]);
    curYear = 7'(mCur[6]);
    #1;
    rdVal = int'(regRdData);
    @(posedge clk);
    aEvt = tick && modelMatch();
    rdS  = rd && (addr == 'h04);
    nSta = (rdS ? 0 : mSta) | (tick ? 2 : 0) | (aEvt ? 1 : 0);
    nArm = (rdS ? 0 : mArm) | ((tick && mEn[1]) ? 2 : 0) | ((aEvt && mEn[0]) ? 1 : 0);
    if (wr && addr == 'h08) mEn = data & 7;
    else if (aEvt && mEn[0] && mEn[2]) mEn = mEn & 6;
    if (wr && addr == 'h10) mMask = data & 'h7f;
    for (int i = 0; i < 7; i++) begin
      if (wr && addr == 'h30 + 4 * i) mAlarm[i] = data & ((1 << fw(i)) - 1);
    end
    mSta = nSta;
    mArm = nArm;
    @(negedge clk);
    tickIn = 0; regWrEn = 0; regRdEn = 0;
    check("R7 irq level", int'(irqN), (mArm != 0) ? 0 : 1);
  endtask

  task automatic wrReg(input int addr, input int data);
    int d;
    cycle(0, 1, 0, addr, data, d);
  endtask

  task automatic rdReg(input int addr, output int v);
    cycle(0, 0, 1, addr, 0, v);
  endtask

  task automatic tick1();
    int d;
    cycle(1, 0, 0, 0, 0, d);
  endtask

  task automatic setCurToAlarm();
    for (int i = 0; i < 7; i++) mCur[i] = mAlarm[i];
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    int v;
    int d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 7; i++) begin mAlarm[i] = 0; mCur[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irqN", int'(irqN), 1);
    rdReg('h04, v); check("R1 status", v, 0);
    rdReg('h08, v); check("R1 enable", v, 0);
    rdReg('h10, v); check("R1 mask", v, 0);
    rdReg('h30, v); check("R1 second field", v, 0);

    // R2 width truncation
    for (int i = 0; i < 7; i++) begin
      wrReg('h30 + 4 * i, 'hffff);
      rdReg('h30 + 4 * i, v);
      check("R2 field width", v, (1 << fw(i)) - 1);
    end
    wrReg('h10, 'hffff); rdReg('h10, v); check("R2 mask width", v, 'h7f);
    wrReg('h08, 'hfff8); rdReg('h08, v); check("R2 enable width", v, 0);
    wrReg('h10, 0);

    // program alarm 2025-06-12 dow3 09:15:30
    wrReg('h30, 30); wrReg('h34, 15); wrReg('h38, 9); wrReg('h3c, 12);
    wrReg('h40, 3);  wrReg('h44, 6);  wrReg('h48, 25);

    // R3 tick sets status with enables off
    setCurToAlarm(); mCur[0] = 31;
    tick1();
    rdReg('h04, v); check("R3 tick status", v, 2);
    check("R3 no irq when disabled", int'(irqN), 1);
    rdReg('h04, v); check("R6 cleared after read", v, 0);

    // R4 match needs a tick
    setCurToAlarm();
    cycle(0, 0, 0, 0, 0, d);
    rdReg('h04, v); check("R4 no tick no event", v, 0);
    tick1();
    rdReg('h04, v); check("R4 match on tick", v, 3);

    // R5 masking
    mCur[4] = 5;
    tick1(); rdReg('h04, v); check("R5 dow mismatch", v, 2);
    wrReg('h10, 'h10);
    tick1(); rdReg('h04, v); check("R5 dow masked", v, 3);
    wrReg('h10, 'h01); setCurToAlarm(); mCur[0] = 0;
    tick1(); rdReg('h04, v); check("R5 second masked", v, 3);
    wrReg('h10, 0);

    // R6 event in read cycle survives
    tick1();
    cycle(1, 0, 1, 'h04, 0, v); check("R6 read returns old", v, 2);
    rdReg('h04, v); check("R6 same-cycle event kept", v, 2);
    rdReg('h04, v); check("R6 clear", v, 0);

    // R7 alarm enabled interrupt holds until read
    wrReg('h08, 1); setCurToAlarm();
    tick1(); check("R7 irq asserted", int'(irqN), 0);
    repeat (5) cycle(0, 0, 0, 0, 0, d);
    check("R7 irq held", int'(irqN), 0);
    rdReg('h04, v); check("R7 status", v, 3);
    check("R7 irq released", int'(irqN), 1);
    wrReg('h08, 2); mCur[0] = 1;
    tick1(); check("R7 tick irq", int'(irqN), 0);
    rdReg('h04, v); check("R7 tick irq released", int'(irqN), 1);

    // R8 one-shot
    wrReg('h08, 5); setCurToAlarm();
    tick1(); check("R8 irq on one-shot fire", int'(irqN), 0);
    rdReg('h08, v); check("R8 alarm enable cleared", v, 4);
    rdReg('h04, v);
    tick1(); check("R8 disarmed no irq", int'(irqN), 1);
    rdReg('h04, v); check("R8 status still set", v, 3);
    wrReg('h08, 1);
    tick1(); tick1();
    rdReg('h08, v); check("R8 enable kept without one-shot", v, 1);
    rdReg('h04, v);

    // R9 write beats self-clear
    wrReg('h08, 5);
    cycle(1, 1, 0, 'h08, 5, d);
    rdReg('h08, v); check("R9 write wins", v, 5);
    rdReg('h04, v);

    // R10 late enable does not raise irq
    wrReg('h08, 0);
    tick1();
    wrReg('h08, 3);
    check("R10 no irq for old status", int'(irqN), 1);
    cycle(0, 0, 0, 0, 0, d);
    check("R10 still no irq", int'(irqN), 1);
    rdReg('h04, v); check("R10 status pending", v, 3);
    wrReg('h08, 0);

    // constrained random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      int addr;
      int data;
      bit tk;
      bit wr;
      bit rd;
      int exp;
      for (int i = 0; i < 7; i++) begin
        if ($urandom % 4 != 0) mCur[i] = mAlarm[i];
        else mCur[i] = int'($urandom % (1 << fw(i)));
      end
      tk = ($urandom % 2) == 0;
      op = int'($urandom % 20);
      wr = 0; rd = 0; addr = 0; data = int'($urandom % 'h10000);
      if (op < 2)      begin wr = 1; addr = 'h10; end
      else if (op < 4) begin wr = 1; addr = 'h08; end
      else if (op < 5) begin wr = 1; addr = 'h30 + 4 * int'($urandom % 7); end
      else if (op < 10) begin rd = 1; addr = 'h04; end
      else if (op < 12) begin rd = 1; addr = ($urandom % 2) ? 'h08 : 'h10; end
      exp = modelRead(addr);
      cycle(tk, wr, rd, addr, data, v);
      if (rd) check((addr == 'h04) ? "R6 random status" : "R2 random readback", v, exp);
    end

    finish();
  end

endmodule